// File: doc/BRIEF.md
# Multi-Target Interrupt Routing Controller

This block gathers 64 interrupt request lines, arranged as a 32-bit common group (sources present on both older and newer hardware) and a 32-bit extended group (sources that exist only on newer hardware). It delivers them to four targets: three application cores and one I/O processor. Each target keeps its own copy of the pending flags for both groups, so every core can acknowledge an event without disturbing the view of the others.

A source that is high on a clock edge sets its flag in all four targets at once. Software clears a flag by writing 1 to its bit in that target's status register. Each target has an enable mask per group, and its interrupt output is high whenever any enabled flag is pending. The I/O processor has a second, independent mask pair that drives a fast-interrupt output. A flat 32-bit register port with a 12-bit byte offset gives access to everything, and a small compatibility window at low offsets aliases the common-group registers of application core 0 and the I/O processor.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every status, enable and fast-interrupt enable register reads 0, and all interrupt outputs are low.
- R2: A source bit high at a clock edge sets the matching flag in the status register of all four targets for that group (common group: application core n status at 0x440+16n, I/O status at 0x470; extended group: 0x444+16n and 0x474); no flag becomes set without its source.
- R3: Writing 1 to a status bit clears it; writing 0 leaves it unchanged, and no flag clears without a write.
- R4: Application core n raises `app_irq_o[n]` one cycle after a flag and its enable bit are both set, in either group (enables at 0x448+16n common, 0x44C+16n extended); a pending flag without enable leaves the output low.
- R5: A clear written to one target's status register leaves the other targets' copies of the same flag set.
- R6: The I/O processor's `io_irq_o` uses the enables at 0x478/0x47C and `io_fiq_o` uses the separate enables at 0x480/0x484; each output ignores the other's mask.
- R7: The compatibility window aliases storage: 0x030 is application core 0 common status, 0x034 its common enable, 0x038 the I/O common status, 0x03C the I/O common interrupt enable, 0x040 the I/O common fast-interrupt enable.
- R8: When a source is high in the same cycle as a write-1 clear of its flag, the flag stays set.
- R9: Reads of an undefined or misaligned offset return 0, and writes to them change no register.
- R10: Enable registers read back exactly the 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_common_i | input | 32 | Common-group interrupt sources |
| src_ext_i | input | 32 | Extended-group interrupt sources |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset (combinational) |
| app_irq_o | output | 3 | Interrupt to each application core |
| io_irq_o | output | 1 | Interrupt to the I/O processor |
| io_fiq_o | output | 1 | Fast interrupt to the I/O processor |

## Verification
On every cycle the assertions confirm that a source event lands in all four targets' flags, that no flag appears without a source, that no flag drops when the bus is idle, and that no output is high while its target has nothing pending. Only the bench's scenarios can show the address map itself: that each offset and its compatibility alias reach the right storage, that a clear on one target spares the others, that the two I/O masks act independently, that a set beats a simultaneous clear, and that undefined offsets read zero and absorb writes.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int unsigned GRP_W      = 32;
    localparam int unsigned NUM_GRP    = 2;
    localparam int unsigned NUM_APP    = 3;
    localparam int unsigned NUM_TGT    = NUM_APP + 1;
    localparam int unsigned IO_TGT     = NUM_APP;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned TGT_W      = $clog2(NUM_TGT);
    localparam int unsigned GIDX_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    // main window: one row per target, then a row of fast-interrupt masks
    localparam int unsigned WIN_BASE   = 32'h440;
    localparam int unsigned WIN_STRIDE = 16;
    localparam int unsigned WIN_END    = WIN_BASE + NUM_TGT * WIN_STRIDE + NUM_GRP * 4;
    // compatibility window
    localparam int unsigned LEG_BASE   = 32'h030;
    localparam int unsigned LEG_SLOTS  = 5;

    typedef logic [GRP_W-1:0]              word_t;
    typedef logic [NUM_GRP-1:0][GRP_W-1:0] grp_vec_t;
    typedef logic [TGT_W-1:0]              tgt_idx_t;
    typedef logic [GIDX_W-1:0]             grp_idx_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_STAT,
        REG_EN,
        REG_FIQ
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        tgt_idx_t  tgt;
        grp_idx_t  grp;
    } reg_sel_t;

    typedef struct packed {
        grp_vec_t stat;
        grp_vec_t en;
        grp_vec_t fiq_en;
    } tgt_state_t;

endpackage

// File: rtl/irqr_decode.sv
module irqr_decode
    import irqr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    always_comb begin
        int unsigned ofs;
        int unsigned rel;
        int unsigned row;
        int unsigned slot;

        sel_o = '{kind: REG_NONE, tgt: '0, grp: '0};
        ofs   = 32'(addr_i);
        rel   = 0;
        row   = 0;
        slot  = 0;

        if ((ofs % 4) == 0) begin
            if (ofs >= LEG_BASE && ofs < LEG_BASE + LEG_SLOTS * 4) begin
                // every alias targets the common group
                case ((ofs - LEG_BASE) / 4)
                    0: begin
                        sel_o.kind = REG_STAT;
                        sel_o.tgt  = '0;
                    end
                    1: begin
                        sel_o.kind = REG_EN;
                        sel_o.tgt  = '0;
                    end
                    2: begin
                        sel_o.kind = REG_STAT;
                        sel_o.tgt  = tgt_idx_t'(IO_TGT);
                    end
                    3: begin
                        sel_o.kind = REG_EN;
                        sel_o.tgt  = tgt_idx_t'(IO_TGT);
                    end
                    default: begin
                        sel_o.kind = REG_FIQ;
                        sel_o.tgt  = tgt_idx_t'(IO_TGT);
                    end
                endcase
            end else if (ofs >= WIN_BASE && ofs < WIN_END) begin
                rel  = ofs - WIN_BASE;
                row  = rel / WIN_STRIDE;
                slot = (rel % WIN_STRIDE) / 4;
                if (row < NUM_TGT) begin
                    sel_o.tgt = tgt_idx_t'(row);
                    if (slot < NUM_GRP) begin
                        sel_o.kind = REG_STAT;
                        sel_o.grp  = grp_idx_t'(slot);
                    end else if (slot < 2 * NUM_GRP) begin
                        sel_o.kind = REG_EN;
                        sel_o.grp  = grp_idx_t'(slot - NUM_GRP);
                    end
                end else if (slot < NUM_GRP) begin
                    sel_o.kind = REG_FIQ;
                    sel_o.tgt  = tgt_idx_t'(IO_TGT);
                    sel_o.grp  = grp_idx_t'(slot);
                end
            end
        end
    end

endmodule

// File: rtl/irqr_target.sv
module irqr_target
    import irqr_pkg::*;
#(
    parameter bit HAS_FIQ = 1'b0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  grp_vec_t           src_i,
    input  logic [NUM_GRP-1:0] stat_we_i,
    input  logic [NUM_GRP-1:0] en_we_i,
    input  logic [NUM_GRP-1:0] fiq_we_i,
    input  word_t              wdata_i,
    output grp_vec_t           stat_o,
    output grp_vec_t           en_o,
    output grp_vec_t           fiq_en_o,
    output logic               irq_o,
    output logic               fiq_o
);

    tgt_state_t st_d, st_q;

    always_comb begin
        word_t clr;
        st_d  = st_q;
        irq_o = 1'b0;
        fiq_o = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            clr = stat_we_i[g] ? wdata_i : '0;
            // a source set outranks a simultaneous clear
            st_d.stat[g] = (st_q.stat[g] & ~clr) | src_i[g];
            if (en_we_i[g]) begin
                st_d.en[g] = wdata_i;
            end
            if (HAS_FIQ && fiq_we_i[g]) begin
                st_d.fiq_en[g] = wdata_i;
            end
            if (!HAS_FIQ) begin
                st_d.fiq_en[g] = '0;
            end
            irq_o = irq_o | (|(st_q.stat[g] & st_q.en[g]));
            fiq_o = fiq_o | (|(st_q.stat[g] & st_q.fiq_en[g]));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o   = st_q.stat;
    assign en_o     = st_q.en;
    assign fiq_en_o = st_q.fiq_en;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irqr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [GRP_W-1:0]  src_common_i,
    input  logic [GRP_W-1:0]  src_ext_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [GRP_W-1:0]  bus_wdata_i,
    output logic [GRP_W-1:0]  bus_rdata_o,
    output logic [NUM_APP-1:0] app_irq_o,
    output logic              io_irq_o,
    output logic              io_fiq_o
);

    grp_vec_t                   src_all;
    reg_sel_t                   sel;
    grp_vec_t [NUM_TGT-1:0]     stat_all;
    grp_vec_t [NUM_TGT-1:0]     en_all;
    grp_vec_t [NUM_TGT-1:0]     fiq_all;
    logic     [NUM_TGT-1:0]     tgt_irq;
    logic     [NUM_TGT-1:0]     tgt_fiq;
    logic [NUM_TGT-1:0][NUM_GRP-1:0] stat_we;
    logic [NUM_TGT-1:0][NUM_GRP-1:0] en_we;
    logic [NUM_TGT-1:0][NUM_GRP-1:0] fiq_we;
    logic [NUM_TGT-1:0][NUM_GRP-1:0][GRP_W-1:0] flags_all;

    assign src_all = {src_ext_i, src_common_i};

    irqr_decode u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign stat_we[t][g] = bus_wr_i && sel.kind == REG_STAT
                                   && sel.tgt == tgt_idx_t'(t) && sel.grp == grp_idx_t'(g);
            assign en_we[t][g]   = bus_wr_i && sel.kind == REG_EN
                                   && sel.tgt == tgt_idx_t'(t) && sel.grp == grp_idx_t'(g);
            assign fiq_we[t][g]  = bus_wr_i && sel.kind == REG_FIQ && (t == IO_TGT)
                                   && sel.grp == grp_idx_t'(g);
        end

        irqr_target #(
            .HAS_FIQ (t == IO_TGT)
        ) u_target (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .src_i     (src_all),
            .stat_we_i (stat_we[t]),
            .en_we_i   (en_we[t]),
            .fiq_we_i  (fiq_we[t]),
            .wdata_i   (bus_wdata_i),
            .stat_o    (stat_all[t]),
            .en_o      (en_all[t]),
            .fiq_en_o  (fiq_all[t]),
            .irq_o     (tgt_irq[t]),
            .fiq_o     (tgt_fiq[t])
        );

        assign flags_all[t] = stat_all[t];
    end

    for (genvar a = 0; a < NUM_APP; a++) begin : g_app_out
        assign app_irq_o[a] = tgt_irq[a];
    end

    assign io_irq_o = tgt_irq[IO_TGT];
    assign io_fiq_o = tgt_fiq[IO_TGT];

    logic unused_fiq;
    assign unused_fiq = &{1'b0, tgt_fiq};

    always_comb begin
        bus_rdata_o = '0;
        case (sel.kind)
            REG_STAT: bus_rdata_o = stat_all[sel.tgt][sel.grp];
            REG_EN:   bus_rdata_o = en_all[sel.tgt][sel.grp];
            REG_FIQ:  bus_rdata_o = fiq_all[sel.tgt][sel.grp];
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
    import irqr_pkg::*;
(
    input logic                                   clk_i,
    input logic                                   rst_ni,
    input logic [GRP_W-1:0]                       src_common_i,
    input logic [GRP_W-1:0]                       src_ext_i,
    input logic                                   bus_wr_i,
    input logic [NUM_TGT-1:0][NUM_GRP-1:0][GRP_W-1:0] flags_all,
    input logic [NUM_APP-1:0]                     app_irq_o,
    input logic                                   io_irq_o,
    input logic                                   io_fiq_o
);

    grp_vec_t src_v;
    assign src_v = {src_ext_i, src_common_i};

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_g
            AST_SRC_REACHES_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> ((flags_all[t][g] & $past(src_v[g])) == $past(src_v[g]))); // R2
            AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> ((flags_all[t][g] & ~$past(flags_all[t][g]) & ~$past(src_v[g])) == '0)); // R2
            AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && !$past(bus_wr_i)) |-> ((~flags_all[t][g] & $past(flags_all[t][g])) == '0)); // R3
        end
    end

    for (genvar a = 0; a < NUM_APP; a++) begin : g_a
        AST_APP_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            app_irq_o[a] |-> (|flags_all[a])); // R4
    end

    AST_IO_OUT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_irq_o || io_fiq_o) |-> (|flags_all[IO_TGT])); // R6

endmodule

bind irq_route_ctrl irqr_checker u_irqr_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_common_i (src_common_i),
    .src_ext_i    (src_ext_i),
    .bus_wr_i     (bus_wr_i),
    .flags_all    (flags_all),
    .app_irq_o    (app_irq_o),
    .io_irq_o     (io_irq_o),
    .io_fiq_o     (io_fiq_o)
);

// File: tb/test_irq_route_ctrl.sv
`timescale 1ns/1ps
module test_irq_route_ctrl;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] src_common_i = '0;
    logic [31:0] src_ext_i = '0;
    logic [11:0] bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [2:0]  app_irq_o;
    logic        io_irq_o;
    logic        io_fiq_o;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #10 clk_i = ~clk_i;

    irq_route_ctrl i_irq_route_ctrl (
        .clk_i, .rst_ni, .src_common_i, .src_ext_i, .bus_addr_i,
        .bus_wr_i, .bus_wdata_i, .bus_rdata_o, .app_irq_o, .io_irq_o, .io_fiq_o
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        src_common_i = '0;
        src_ext_i = '0;
        bus_wr_i = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk_i);
        bus_addr_i = a;
        bus_wdata_i = d;
        bus_wr_i = 1'b1;
        @(negedge clk_i);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic pulse(input bit ext, input int b);
        @(negedge clk_i);
        if (ext) src_ext_i[b] = 1'b1; else src_common_i[b] = 1'b1;
        @(negedge clk_i);
        src_ext_i = '0;
        src_common_i = '0;
    endtask

    task automatic t_reset();
        do_reset();
        rd(12'h440, rv); chk("R1 app0 common status", rv, 0);
        rd(12'h474, rv); chk("R1 io ext status", rv, 0);
        rd(12'h458, rv); chk("R1 app1 common enable", rv, 0);
        rd(12'h484, rv); chk("R1 io ext fiq enable", rv, 0);
        rd(12'h030, rv); chk("R1 alias status", rv, 0);
        chk("R1 outputs", {27'd0, app_irq_o, io_irq_o, io_fiq_o}, 0);
    endtask

    task automatic t_fanout();
        do_reset();
        pulse(0, 5);
        for (int t = 0; t < 4; t++) begin
            rd(12'(12'h440 + 16 * t), rv); chk("R2 common flag in every target", rv, 32'h20);
        end
        rd(12'h444, rv); chk("R2 ext untouched", rv, 0);
        pulse(1, 0);
        rd(12'h474, rv); chk("R2 io ext flag", rv, 32'h1);
        rd(12'h464, rv); chk("R2 app2 ext flag", rv, 32'h1);
    endtask

    task automatic t_enable();
        do_reset();
        pulse(0, 5);
        chk("R4 no enable keeps low", {29'd0, app_irq_o}, 0);
        wr(12'h458, 32'h20);
        chk("R4 app1 raised", {29'd0, app_irq_o}, 32'h2);
        wr(12'h458, 32'h10);
        chk("R4 mismatched enable", {29'd0, app_irq_o}, 0);
        wr(12'h46C, 32'h1);
        pulse(1, 0);
        chk("R4 app2 via ext group", {29'd0, app_irq_o}, 32'h4);
    endtask

    task automatic t_w1c();
        do_reset();
        pulse(0, 5);
        pulse(0, 6);
        wr(12'h450, 32'h0);
        rd(12'h450, rv); chk("R3 write 0 no effect", rv, 32'h60);
        wr(12'h450, 32'h20);
        rd(12'h450, rv); chk("R3 write 1 clears", rv, 32'h40);
        rd(12'h440, rv); chk("R5 app0 copy kept", rv, 32'h60);
        rd(12'h470, rv); chk("R5 io copy kept", rv, 32'h60);
    endtask

    task automatic t_io();
        do_reset();
        wr(12'h484, 32'h80);
        pulse(1, 7);
        chk("R6 fiq raised", {31'd0, io_fiq_o}, 1);
        chk("R6 irq ignores fiq mask", {31'd0, io_irq_o}, 0);
        wr(12'h47C, 32'h80);
        chk("R6 irq raised", {31'd0, io_irq_o}, 1);
        wr(12'h484, 32'h0);
        chk("R6 fiq dropped alone", {30'd0, io_irq_o, io_fiq_o}, 32'h2);
    endtask

    task automatic t_legacy();
        do_reset();
        wr(12'h034, 32'hA5);
        rd(12'h448, rv); chk("R7 alias app0 enable", rv, 32'hA5);
        wr(12'h03C, 32'h3);
        rd(12'h478, rv); chk("R7 alias io enable", rv, 32'h3);
        wr(12'h040, 32'h11);
        rd(12'h480, rv); chk("R7 alias io fiq enable", rv, 32'h11);
        pulse(0, 2);
        rd(12'h038, rv); chk("R7 alias io status", rv, 32'h4);
        wr(12'h038, 32'h4);
        rd(12'h470, rv); chk("R7 alias clear reaches io", rv, 0);
        rd(12'h030, rv); chk("R7 alias app0 status", rv, 32'h4);
    endtask

    task automatic t_collide();
        do_reset();
        pulse(0, 9);
        @(negedge clk_i);
        src_common_i[9] = 1'b1;
        bus_addr_i = 12'h440;
        bus_wdata_i = 32'h200;
        bus_wr_i = 1'b1;
        @(negedge clk_i);
        src_common_i = '0;
        bus_wr_i = 1'b0;
        rd(12'h440, rv); chk("R8 set beats clear", rv, 32'h200);
        wr(12'h440, 32'h200);
        rd(12'h440, rv); chk("R8 later clear works", rv, 0);
    endtask

    task automatic t_undef();
        do_reset();
        wr(12'h488, 32'hFFFF_FFFF);
        wr(12'h44A, 32'hFFFF_FFFF);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h488, rv); chk("R9 undefined reads 0", rv, 0);
        rd(12'h44A, rv); chk("R9 misaligned reads 0", rv, 0);
        rd(12'h044, rv); chk("R9 past alias reads 0", rv, 0);
        rd(12'h448, rv); chk("R9 app0 enable untouched", rv, 0);
        rd(12'h480, rv); chk("R9 fiq enable untouched", rv, 0);
        pulse(0, 1);
        chk("R9 outputs stay low", {27'd0, app_irq_o, io_irq_o, io_fiq_o}, 0);
    endtask

    task automatic t_rw();
        do_reset();
        wr(12'h45C, 32'hDEAD_BEEF);
        rd(12'h45C, rv); chk("R10 app1 ext enable", rv, 32'hDEAD_BEEF);
        wr(12'h468, 32'h1234_5678);
        rd(12'h468, rv); chk("R10 app2 common enable", rv, 32'h1234_5678);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fanout();
                t_enable();
                t_w1c();
                t_io();
                t_legacy();
                t_collide();
                t_undef();
                t_rw();
            end
            begin
                repeat (20000) @(posedge clk_i);
                total++;
                bad++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule